// File: doc/BRIEF.md
# Flag-Based Conditional Branch Unit

This block decides whether a conditional branch is taken and computes the next program counter. It takes the current PC, a 4-bit condition code, a 9-bit signed displacement and five status flags: zero, sign, overflow, carry and saturation. It uses these to select either the branch target or the fall-through address. The decision and the next PC are captured in output registers on each clock edge where the instruction-valid strobe is high.

The same condition evaluator also drives a combinational 0/1 output. A set-on-condition instruction can write this value straight into a register, so the branch path and the flag-to-register path share one decode of the sixteen conditions.

The block does not fetch or decode instructions, produce flags or handle pipeline hazards. Those tasks belong to the surrounding core.

Top module: `brc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `npc_o` becomes 0 and `taken_o` becomes 0 after that edge.
- R2: The flag vector is {SAT, CY, OV, S, Z}, with Z at bit 0 and SAT at bit 4. Codes 0x0 and 0x8 are true when OV is set and when OV is clear, respectively. Codes 0x1 and 0x9 do the same for CY, codes 0x2 and 0xA for Z, and codes 0x4 and 0xC for S.
- R3: Code 0x3 is true when CY or Z is set (unsigned not-higher). Code 0xB is true when both CY and Z are clear (unsigned higher).
- R4: Code 0x6 is true when S XOR OV is 1 (signed less). Code 0xE is true when S XOR OV is 0 (signed greater-or-equal).
- R5: Code 0x7 is true when Z OR (S XOR OV) is 1. Code 0xF is true when that expression is 0.
- R6: Code 0x5 is true for every flag value. Code 0xD is true exactly when SAT is set.
- R7: On a valid edge with a true condition, `taken_o` becomes 1. `npc_o` becomes `pc_i` plus the sign-extended 9-bit displacement, modulo 2^PC_W.
- R8: On a valid edge with a false condition, `taken_o` becomes 0 and `npc_o` becomes `pc_i + 2`, modulo 2^PC_W.
- R9: On an edge where `valid_i` is low and `rst` is low, `npc_o` and `taken_o` keep their values, whatever the other inputs are.
- R10: `cond_true_o` reflects the condition for the current `cond_i` and `flags_i` combinationally, in the same cycle, whether or not `valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction-valid strobe; enables the output registers |
| pc_i | input | PC_W | Address of the current instruction |
| cond_i | input | 4 | Condition code |
| disp_i | input | DISP_W | Signed branch displacement |
| flags_i | input | 5 | Status flags {SAT, CY, OV, S, Z} |
| cond_true_o | output | 1 | Combinational condition result for set-on-condition use |
| taken_o | output | 1 | Registered branch-taken decision |
| npc_o | output | PC_W | Registered next program counter |

## Verification
The bench builds the unit with PC_W=16, DISP_W=9 and STEP=2. This small PC width lets the bench reach address wrap-around at the top of the space with a handful of PC values.

The bench sweeps all 16 condition codes against all 32 flag combinations. For each pair it checks the combinational result, the registered decision and the chosen address. It also sweeps all 512 displacements, both taken and not taken, from PCs near zero and near the top of the address space.

Hold behaviour is checked by changing every input with the strobe low. Reset is checked both at start-up and in the middle of the run.

// File: rtl/brc_pkg.sv
`timescale 1ns/1ps
package brc_pkg;

  // Condition encodings; the numeric values are decoded by the instruction word.
  typedef enum logic [3:0] {
    BC_OV  = 4'h0,
    BC_CY  = 4'h1,
    BC_Z   = 4'h2,
    BC_NH  = 4'h3,
    BC_S   = 4'h4,
    BC_AL  = 4'h5,
    BC_LT  = 4'h6,
    BC_LE  = 4'h7,
    BC_NOV = 4'h8,
    BC_NCY = 4'h9,
    BC_NZ  = 4'hA,
    BC_H   = 4'hB,
    BC_NS  = 4'hC,
    BC_SAT = 4'hD,
    BC_GE  = 4'hE,
    BC_GT  = 4'hF
  } brc_code_e;

  // Status flags, bit 0 = zero ... bit 4 = saturation.
  typedef struct packed {
    logic sat;
    logic cy;
    logic ov;
    logic s;
    logic z;
  } brc_flags_t;

endpackage

// File: rtl/brc_cond_eval.sv
`timescale 1ns/1ps
module brc_cond_eval
  import brc_pkg::*;
(
  input  logic [3:0] code_i,
  input  brc_flags_t flg_i,
  output logic       hit_o
);

  logic lt;
  logic le;
  logic nh;

  assign lt = flg_i.s ^ flg_i.ov;
  assign le = flg_i.z | lt;
  assign nh = flg_i.cy | flg_i.z;

  always_comb begin
    hit_o = 1'b0;
    case (brc_code_e'(code_i))
      BC_OV:  hit_o = flg_i.ov;
      BC_CY:  hit_o = flg_i.cy;
      BC_Z:   hit_o = flg_i.z;
      BC_NH:  hit_o = nh;
      BC_S:   hit_o = flg_i.s;
      BC_AL:  hit_o = 1'b1;
      BC_LT:  hit_o = lt;
      BC_LE:  hit_o = le;
      BC_NOV: hit_o = ~flg_i.ov;
      BC_NCY: hit_o = ~flg_i.cy;
      BC_NZ:  hit_o = ~flg_i.z;
      BC_H:   hit_o = ~nh;
      BC_NS:  hit_o = ~flg_i.s;
      BC_SAT: hit_o = flg_i.sat;
      BC_GE:  hit_o = ~lt;
      BC_GT:  hit_o = ~le;
    endcase
  end

  // R6
  always_comb begin
    if (code_i == 4'h5) begin
      always_chk: assert (hit_o == 1'b1);
    end
  end

endmodule

// File: rtl/brc_target.sv
`timescale 1ns/1ps
module brc_target #(
  parameter int PC_W   = 32,
  parameter int DISP_W = 9,
  parameter int STEP   = 2
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              take_i,
  output logic [PC_W-1:0]   npc_o
);

  localparam int EXT_W = (PC_W > DISP_W) ? (PC_W - DISP_W) : 0;

  logic [PC_W-1:0] disp_ext;
  logic [PC_W-1:0] br_addr;
  logic [PC_W-1:0] seq_addr;

  generate
    if (EXT_W > 0) begin : g_sext
      assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_trunc
      assign disp_ext = disp_i[PC_W-1:0];
    end
  endgenerate

  assign br_addr  = pc_i + disp_ext;
  assign seq_addr = pc_i + PC_W'(STEP);
  assign npc_o    = take_i ? br_addr : seq_addr;

endmodule

// File: rtl/brc_unit.sv
`timescale 1ns/1ps
module brc_unit
  import brc_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DISP_W = 9,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [3:0]        cond_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [4:0]        flags_i,
  output logic              cond_true_o,
  output logic              taken_o,
  output logic [PC_W-1:0]   npc_o
);

  brc_flags_t      flg;
  logic            hit;
  logic [PC_W-1:0] nxt;
  logic [PC_W-1:0] npc_q;
  logic            taken_q;

  assign flg = brc_flags_t'(flags_i);

  brc_cond_eval u_eval (
    .code_i (cond_i),
    .flg_i  (flg),
    .hit_o  (hit)
  );

  brc_target #(
    .PC_W   (PC_W),
    .DISP_W (DISP_W),
    .STEP   (STEP)
  ) u_tgt (
    .pc_i   (pc_i),
    .disp_i (disp_i),
    .take_i (hit),
    .npc_o  (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      npc_q   <= '0;
      taken_q <= 1'b0;
    end else if (valid_i) begin
      npc_q   <= nxt;
      taken_q <= hit;
    end
  end

  assign cond_true_o = hit;
  assign taken_o     = taken_q;
  assign npc_o       = npc_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (npc_o == '0 && !taken_o));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(npc_o) && $stable(taken_o)));

  // R7
  taken_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && cond_true_o) |=> taken_o);

  // R8
  fallthru_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !cond_true_o) |=> (!taken_o && npc_o == $past(pc_i) + PC_W'(STEP)));

endmodule

// File: tb/tb_brc_unit.sv
`timescale 1ns/1ps
module tb_brc_unit;

  localparam int PW = 16;
  localparam int DW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid_i = 1'b0;
  logic [PW-1:0] pc_i = '0;
  logic [3:0]    cond_i = '0;
  logic [DW-1:0] disp_i = '0;
  logic [4:0]    flags_i = '0;
  logic          cond_true_o;
  logic          taken_o;
  logic [PW-1:0] npc_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  brc_unit #(.PC_W(PW), .DISP_W(DW), .STEP(2)) dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .pc_i(pc_i), .cond_i(cond_i),
    .disp_i(disp_i), .flags_i(flags_i), .cond_true_o(cond_true_o),
    .taken_o(taken_o), .npc_o(npc_o)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  // Reference condition: flags {sat,cy,ov,s,z}
  function automatic bit ref_cond(input logic [3:0] c, input logic [4:0] f);
    bit z, s, ov, cy, sat, b;
    z = f[0]; s = f[1]; ov = f[2]; cy = f[3]; sat = f[4];
    if (c == 4'h5) return 1'b1;
    if (c == 4'hD) return sat;
    case (c[2:0])
      3'd0: b = ov;
      3'd1: b = cy;
      3'd2: b = z;
      3'd3: b = cy | z;
      3'd4: b = s;
      3'd6: b = s ^ ov;
      default: b = z | (s ^ ov);
    endcase
    return c[3] ? !b : b;
  endfunction

  function automatic string req_of(input logic [3:0] c);
    case (c[2:0])
      3'd3: return "R3";
      3'd5: return "R6";
      3'd6: return "R4";
      3'd7: return "R5";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [PW-1:0] ref_npc(input logic [PW-1:0] pc,
                                            input logic [DW-1:0] d, input bit tk);
    int sd;
    sd = d[DW-1] ? int'(d) - (1 << DW) : int'(d);
    return tk ? PW'(int'(pc) + sd) : PW'(int'(pc) + 2);
  endfunction

  task automatic step(input logic [PW-1:0] pc, input logic [3:0] c,
                      input logic [DW-1:0] d, input logic [4:0] f);
    bit exp_t;
    logic [PW-1:0] exp_n;
    @(negedge clk);
    valid_i = 1'b1; pc_i = pc; cond_i = c; disp_i = d; flags_i = f;
    exp_t = ref_cond(c, f);
    exp_n = ref_npc(pc, d, exp_t);
    #1;
    chk(cond_true_o == exp_t, {req_of(c), "/R10"}, "cond_true", cond_true_o, exp_t);
    @(posedge clk); #1;
    chk(taken_o == exp_t, req_of(c), "taken", taken_o, exp_t);
    chk(npc_o == exp_n, exp_t ? "R7" : "R8", "npc", npc_o, exp_n);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog all act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [PW-1:0] held_n;
    logic          held_t;
    // R1 start-up reset
    repeat (3) @(posedge clk);
    #1;
    chk(npc_o == '0, "R1", "npc after reset", npc_o, 0);
    chk(taken_o == 1'b0, "R1", "taken after reset", taken_o, 0);
    @(negedge clk); rst = 1'b0;

    // R2..R6, R10: every code against every flag set
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 32; f++) begin
        step(PW'(16'h1000 + c * 64 + f * 2), 4'(c), DW'(f * 13 + c), 5'(f));
      end
    end

    // R7/R8: every displacement, taken (code 5) and not taken (code 0, OV clear)
    for (int d = 0; d < 512; d++) begin
      step(16'hFFF0, 4'h5, 9'(d), 5'b00000);
      step(16'h0008, 4'h5, 9'(d), 5'b10111);
      step(16'hFFFE, 4'h0, 9'(d), 5'b00000);
    end

    // R10: combinational result with valid low
    @(negedge clk);
    valid_i = 1'b0; cond_i = 4'hD; flags_i = 5'b10000; #1;
    chk(cond_true_o == 1'b1, "R10", "cond_true valid low", cond_true_o, 1);

    // R9: hold with valid low while every other input moves
    step(16'h4444, 4'h5, 9'h010, 5'b00000);
    held_n = npc_o; held_t = taken_o;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      valid_i = 1'b0; pc_i = PW'(k * 16'h1357); cond_i = 4'(k * 3);
      disp_i = DW'(k * 77); flags_i = 5'(k * 5);
      @(posedge clk); #1;
      chk(npc_o == held_n, "R9", "npc held", npc_o, held_n);
      chk(taken_o == held_t, "R9", "taken held", taken_o, held_t);
    end

    // R1 mid-run reset with valid high
    step(16'h2222, 4'h5, 9'h020, 5'b00000);
    @(negedge clk);
    rst = 1'b1; valid_i = 1'b1; cond_i = 4'h5;
    @(posedge clk); #1;
    chk(npc_o == '0, "R1", "npc mid reset", npc_o, 0);
    chk(taken_o == 1'b0, "R1", "taken mid reset", taken_o, 0);
    @(negedge clk); rst = 1'b0; valid_i = 1'b0;
    @(posedge clk); #1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule